// File: doc/BRIEF.md
# Periodic Battery Test Scheduler

This block decides when a backup battery is put under a test load and keeps the resulting low-battery warning. Once the supply is valid and a recovery-done strobe reports that the write-protect recovery time has run out, the block runs a power-up test. It then repeats the test once per period for as long as the supply stays valid. During each test it enables an external load for a fixed window and watches a battery-low comparator bit. The analog load and the comparator sit outside the block.

The warning is sticky across periodic tests: a passing periodic test never clears it. The test that follows each power-up is different. Its verdict replaces the warning, so a good battery found after a power cycle clears the flag, and the period count restarts from that test. A supply failure aborts any test in progress and stops the schedule until the next power-up.

The warning leaves the block as an enable for an open-drain pull-down. A parameter chooses whether the pull-down is released while the supply is down.

Top module: `batt_test_sched`

## Requirements
- R1: After reset `load_en` and `warn_pull` are 0, and the stored warning is clear.
- R2: After the supply becomes valid, no test starts until `recovery_done` is seen high at a clock edge while the block is waiting. `load_en` rises in the cycle after that edge. A strobe seen while the supply is invalid, or in the first valid cycle, is ignored.
- R3: Each test holds `load_en` high for exactly `WIN_CYC` consecutive cycles.
- R4: While the supply stays valid, each test starts `PERIOD_CYC` cycles after the previous one started. This leaves `PERIOD_CYC - WIN_CYC` cycles with `load_en` low between windows.
- R5: `batt_low` = 1 on any clock edge inside a window makes that test fail. `batt_low` outside a window has no effect.
- R6: A failing periodic test sets the warning. A passing periodic test leaves the warning unchanged.
- R7: The test started by a power-up strobe sets the warning to its own verdict: fail gives 1 and pass gives 0. The period count restarts from that test.
- R8: If `supply_ok` = 0 at an edge, `load_en` is 0 from the next cycle. Any running test is dropped without changing the warning, and no test runs until a new power-up strobe.
- R9: `warn_pull` = 1 means the open-drain warning line is pulled low. It is 1 when the warning is set and, with `RELEASE_WARN_DOWN` = 1, only while `supply_ok` = 1. The warning changes in the cycle after the last window cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Main supply is above the trip level |
| recovery_done | input | 1 | One-cycle strobe: write-protect recovery time has elapsed |
| batt_low | input | 1 | Comparator output, 1 = battery below threshold under load |
| load_en | output | 1 | Connect the test load |
| warn_pull | output | 1 | Pull-down enable for the open-drain warning line |

## Verification
The bench builds the block with `PERIOD_CYC` = 40 and `WIN_CYC` = 5. This puts several complete periods, several power cycles and aborted windows within a few hundred cycles. It also lets a single low comparator cycle in the middle of a window be placed exactly. The default `RELEASE_WARN_DOWN` = 1 is used, so the released line during a supply failure is checked. The default daily period is only reachable through the counter width, which the same code derives.

// File: rtl/batt_sched_pkg.sv
package batt_sched_pkg;
   typedef enum logic [1:0] {
      ST_OFF  = 2'd0,
      ST_WAIT = 2'd1,
      ST_TEST = 2'd2,
      ST_GAP  = 2'd3
   } sched_st_e;
endpackage

// File: rtl/batt_sched_seq.sv
module batt_sched_seq
   import batt_sched_pkg::*;
#(
   parameter int unsigned PERIOD_CYC = 40,
   parameter int unsigned WIN_CYC    = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic recovery_done,
   output logic in_test,
   output logic test_done,
   output logic pu_test
);
   localparam int unsigned CNT_W = $clog2(PERIOD_CYC);
   localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(WIN_CYC - 1);
   localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(PERIOD_CYC - WIN_CYC - 1);

   initial begin
      assert (WIN_CYC >= 1) else $error("WIN_CYC must be at least 1");
      assert (PERIOD_CYC > WIN_CYC) else $error("PERIOD_CYC must exceed WIN_CYC");
   end

   sched_st_e        st;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_OFF;
         cnt     <= '0;
         pu_test <= 1'b0;
      end else if (!supply_ok) begin
         st      <= ST_OFF;
         cnt     <= '0;
         pu_test <= 1'b0;
      end else begin
         case (st)
            ST_OFF:  st <= ST_WAIT;
            ST_WAIT: if (recovery_done) begin
               st      <= ST_TEST;
               cnt     <= '0;
               pu_test <= 1'b1;
            end
            ST_TEST: if (cnt == WIN_LAST) begin
               st      <= ST_GAP;
               cnt     <= '0;
               pu_test <= 1'b0;
            end else begin
               cnt <= cnt + 1'b1;
            end
            ST_GAP: if (cnt == GAP_LAST) begin
               st  <= ST_TEST;
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
            default: st <= ST_OFF;
         endcase
      end
   end

   assign in_test   = (st == ST_TEST);
   assign test_done = in_test && supply_ok && (cnt == WIN_LAST);

   // R8: a failed supply drops the load on the next cycle
   p_load_needs_power_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> !in_test);
   // R2: leaving the wait state into a test needs the strobe
   p_start_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_test && $past(st == ST_WAIT)) |-> $past(recovery_done));
   // R3: the window closes right after its last cycle
   p_window_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      test_done |=> !in_test);
endmodule

// File: rtl/batt_sched_judge.sv
module batt_sched_judge (
   input  logic clk,
   input  logic rst_n,
   input  logic in_test,
   input  logic test_done,
   input  logic pu_test,
   input  logic batt_low,
   output logic warn
);
   logic fail_acc;
   logic verdict;

   assign verdict = fail_acc | batt_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail_acc <= 1'b0;
         warn     <= 1'b0;
      end else begin
         if (!in_test || test_done) fail_acc <= 1'b0;
         else                       fail_acc <= verdict;
         if (test_done) warn <= pu_test ? verdict : (warn | verdict);
      end
   end

   // R6: the warning only moves at the end of a test window
   p_warn_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !test_done |=> $stable(warn));
   // R6: a periodic test never clears the warning
   p_periodic_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (test_done && !pu_test && warn) |=> warn);
   // R5: low on the last window cycle always fails the test
   p_low_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (test_done && batt_low) |=> warn);
endmodule

// File: rtl/batt_test_sched.sv
module batt_test_sched #(
   parameter int unsigned PERIOD_CYC        = 32'd2831155200,
   parameter int unsigned WIN_CYC           = 32768,
   parameter bit          RELEASE_WARN_DOWN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic recovery_done,
   input  logic batt_low,
   output logic load_en,
   output logic warn_pull
);
   logic in_test;
   logic test_done;
   logic pu_test;
   logic warn;

   batt_sched_seq #(.PERIOD_CYC(PERIOD_CYC), .WIN_CYC(WIN_CYC)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .supply_ok     (supply_ok),
      .recovery_done (recovery_done),
      .in_test       (in_test),
      .test_done     (test_done),
      .pu_test       (pu_test)
   );

   batt_sched_judge u_judge (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_test   (in_test),
      .test_done (test_done),
      .pu_test   (pu_test),
      .batt_low  (batt_low),
      .warn      (warn)
   );

   assign load_en = in_test;

   generate
      if (RELEASE_WARN_DOWN) begin : g_release
         assign warn_pull = warn & supply_ok;
      end else begin : g_hold
         assign warn_pull = warn;
      end
   endgenerate

   // R1: nothing is driven in the first cycle after reset
   p_quiet_after_reset_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!load_en && !warn_pull));
endmodule

// File: tb/tb_batt_test_sched.sv
module tb_batt_test_sched;
   localparam int PER = 40;
   localparam int WIN = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_ok = 1'b0;
   logic recovery_done = 1'b0;
   logic batt_low = 1'b0;
   logic load_en;
   logic warn_pull;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   string cur_req = "R1";

   // reference model: 0 off, 1 waiting, 2 testing, 3 between tests
   int m_state = 0;
   int m_cnt = 0;
   bit m_fail = 0;
   bit m_warn = 0;
   bit m_pu = 0;

   batt_test_sched #(.PERIOD_CYC(PER), .WIN_CYC(WIN)) dut (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
      .recovery_done(recovery_done), .batt_low(batt_low),
      .load_en(load_en), .warn_pull(warn_pull)
   );

   always #2 clk = ~clk;

   task automatic chk(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cyc);
      end
   endtask

   task automatic chk_int(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      bit vrd;
      cyc++;
      chk(cur_req, load_en, (m_state == 2), "load_en vs model");
      chk(cur_req, warn_pull, m_warn && supply_ok, "warn_pull vs model");
      if (!rst_n) begin
         m_state = 0; m_cnt = 0; m_fail = 0; m_warn = 0; m_pu = 0;
      end else if (!supply_ok) begin
         m_state = 0; m_cnt = 0; m_fail = 0; m_pu = 0;
      end else if (m_state == 0) begin
         m_state = 1;
      end else if (m_state == 1) begin
         if (recovery_done) begin
            m_state = 2; m_cnt = 0; m_pu = 1; m_fail = 0;
         end
      end else if (m_state == 2) begin
         vrd = m_fail | batt_low;
         if (m_cnt == WIN - 1) begin
            m_warn = m_pu ? vrd : (m_warn | vrd);
            m_state = 3; m_cnt = 0; m_pu = 0; m_fail = 0;
         end else begin
            m_fail = vrd; m_cnt++;
         end
      end else begin
         if (m_cnt == PER - WIN - 1) begin
            m_state = 2; m_cnt = 0; m_fail = 0;
         end else m_cnt++;
      end
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_rise();
      while (load_en) tick(1);
      while (!load_en) tick(1);
   endtask

   task automatic strobe();
      recovery_done = 1'b1; tick(1); recovery_done = 1'b0;
   endtask

   initial begin
      int n;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk("R1", load_en, 1'b0, "load after reset");
      chk("R1", warn_pull, 1'b0, "warn after reset");

      cur_req = "R2";
      strobe();
      tick(3);
      chk("R2", load_en, 1'b0, "strobe while unpowered ignored");
      supply_ok = 1'b1;
      strobe();
      tick(6);
      chk("R2", load_en, 1'b0, "strobe in first valid cycle ignored");

      cur_req = "R7";
      strobe();
      chk("R2", load_en, 1'b1, "load rises after strobe");
      batt_low = 1'b1;
      n = 0;
      while (load_en) begin n++; tick(1); end
      chk_int("R3", n, WIN, "window length");
      batt_low = 1'b0;
      chk("R7", warn_pull, 1'b1, "power-up fail sets warning");

      cur_req = "R4";
      n = 0;
      while (!load_en) begin n++; tick(1); end
      chk_int("R4", n, PER - WIN, "gap between windows");
      while (load_en) tick(1);
      chk("R6", warn_pull, 1'b1, "periodic pass keeps warning");

      cur_req = "R8";
      wait_rise();
      tick(2);
      supply_ok = 1'b0;
      tick(1);
      chk("R8", load_en, 1'b0, "load drops on supply fail");
      chk("R9", warn_pull, 1'b0, "line released while down");
      tick(5);
      supply_ok = 1'b1;
      tick(4);
      chk("R8", load_en, 1'b0, "schedule suspended until strobe");
      chk("R9", warn_pull, 1'b1, "warning driven again after power-up");
      cur_req = "R7";
      strobe();
      while (load_en) tick(1);
      chk("R7", warn_pull, 1'b0, "power-up pass clears warning");

      cur_req = "R5";
      tick(5);
      batt_low = 1'b1;
      tick(10);
      batt_low = 1'b0;
      wait_rise();
      chk("R5", warn_pull, 1'b0, "low outside window ignored");
      tick(2);
      batt_low = 1'b1;
      tick(1);
      batt_low = 1'b0;
      while (load_en) tick(1);
      chk("R6", warn_pull, 1'b1, "single low cycle in periodic window sets warning");

      cur_req = "R8";
      wait_rise();
      tick(1);
      supply_ok = 1'b0;
      tick(3);
      supply_ok = 1'b1;
      tick(3);
      chk("R8", warn_pull, 1'b1, "aborted test leaves warning");
      cur_req = "R7";
      strobe();
      n = 0;
      while (load_en) begin n++; tick(1); end
      chk_int("R3", n, WIN, "window length after power cycle");
      chk("R7", warn_pull, 1'b0, "second power-up pass clears");
      n = 0;
      while (!load_en) begin n++; tick(1); end
      chk_int("R7", n, PER - WIN, "period restarts from power-up test");
      tick(WIN + 2);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule